// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a parallel NOR-style flash device. It watches bus write cycles and decodes multi-cycle unlock sequences for program, sector or whole-chip erase, and identification. It also decodes single-cycle suspend, resume and exit codes. From these it steps through eight operating modes. The embedded program and erase algorithms are not modelled. An external `done` pulse marks their completion, and a parameterised halt window stands in for the bounded time a running operation needs to pause after a suspend.

On the read side the block chooses what each read cycle returns. It can return array data, supplied by the surrounding array model on `arr_data`, the two identification codes, or a status byte with polling and toggle bits. Suspend can nest: a program may be started inside an erase suspend and then be suspended itself. Identification mode remembers the mode it was entered from and returns to it.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While `rst_n` is low the mode is array read (0) and `ready` is 1, and a low `rst_n` aborts a running erase at once. In array read, a read returns `arr_data`.
- R2: The mode codes are: 0 array read, 1 identification, 2 program, 3 program halting, 4 program suspended, 5 erase, 6 erase halting, 7 erase suspended. `ready` is 0 exactly in modes 2, 3, 5 and 6.
- R3: The sequence AAh, 55h, 90h enters identification. Here AAh and 90h go to offset 555h, 55h goes to offset 2AAh, and an offset is the address bits below the sector field.
- R4: In identification, a read with addr[2:1]=00 returns MFR_ID and a read with addr[2:1]=01 returns DEV_ID. Any other value returns 00h. Any number of such reads may follow one another.
- R5: A write of F0h in identification returns to the mode the block was in when identification was entered: array read, program suspended, or erase suspended.
- R6: The sequence AAh, 55h, A0h at offset 555h, followed by one write of any data, starts a program. That write's sector, addr[ADDR_W-1 -: SECT_W], and data bit 7 are latched. `done` ends the program and returns to array read, or to erase suspended if the program was nested.
- R7: Six writes AAh, 55h, 80h, AAh, 55h, then 10h at offset 555h start a chip erase. If the last write is 30h at any address, they start an erase of that address's sector. `done` returns to array read.
- R8: A write that does not match the expected step of a sequence sends the decoder back to its first step without changing the mode.
- R9: B0h at any address during a program or a sector erase enters the matching halting mode. The halting mode lasts exactly SUSP_LAT cycles and then becomes the suspended mode.
- R10: A write of 30h in a suspended mode resumes the suspended operation.
- R11: A program may start from erase suspended and may itself be suspended. A read to the program-suspended sector or the erase-suspended sector returns the status byte. A read to any other sector returns array data.
- R12: The status byte is as follows. Bit 7 is the inverse of the latched data bit 7 during a program, 0 during an erase, and 1 when suspended. Bit 6 toggles after each status read while `ready` is 0. Bit 2 toggles after each status read while an erase is running or suspended. All other bits are 0.
- R13: A chip erase ignores every write, including B0h. A program or a sector erase ignores every write except B0h, and those ignored writes advance no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read cycle strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| done | input | 1 | Completion pulse of the embedded algorithm |
| arr_data | input | 8 | Array data for the current address |
| mode | output | 3 | Operating mode code |
| ready | output | 1 | 1 when no operation is busy |
| rdata | output | 8 | Selected read data |

## Verification
The bench builds the block with SUSP_LAT=3, ADDR_W=16 and SECT_W=4, and with identification codes 3Eh and 7Ah. A three-cycle halt window is short enough to check each cycle of the halting modes and the exact cycle the suspended mode appears. Sixteen sectors let the erase-suspended sector, the program-suspended sector and an untouched sector be distinct, so that the nested read blocking can be separated from plain array reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_AUTOSEL, M_PROG, M_PHALT, M_PSUSP, M_ERASE, M_EHALT, M_ESUSP
  } mode_e;

  typedef enum logic [2:0] {
    C_NONE, C_EXIT, C_SUSP, C_RESUME, C_AUTOSEL, C_PROG, C_CHIP, C_SECT
  } cmd_e;

  localparam logic [7:0] D_UNLOCK1 = 8'hAA;
  localparam logic [7:0] D_UNLOCK2 = 8'h55;
  localparam logic [7:0] D_SETUP   = 8'h80;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_SECT    = 8'h30;
  localparam logic [7:0] D_RESUME  = 8'h30;
  localparam logic [7:0] D_SUSP    = 8'hB0;
  localparam logic [7:0] D_EXIT    = 8'hF0;

  localparam logic [10:0] A_FIRST  = 11'h555;
  localparam logic [10:0] A_SECOND = 11'h2AA;

  function automatic logic is_busy(mode_e m);
    return (m == M_PROG) || (m == M_PHALT) || (m == M_ERASE) || (m == M_EHALT);
  endfunction
endpackage

// File: rtl/fc_seq_decoder.sv
module fc_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             busy,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       wdata,
  output cmd_e             cmd
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_E1, S_E2, S_E3, S_PGM} step_e;

  step_e step, step_n;
  logic  at_first, at_second;

  assign at_first  = (ofs == OFS_W'(A_FIRST));
  assign at_second = (ofs == OFS_W'(A_SECOND));

  always_comb begin
    cmd    = C_NONE;
    step_n = step;
    if (busy) begin
      step_n = S_IDLE;
      if (wr_en && wdata == D_SUSP) cmd = C_SUSP;
    end else if (wr_en) begin
      step_n = S_IDLE;
      unique case (step)
        S_IDLE: begin
          if (at_first && wdata == D_UNLOCK1) step_n = S_U1;
          else if (wdata == D_EXIT)           cmd = C_EXIT;
          else if (wdata == D_SUSP)           cmd = C_SUSP;
          else if (wdata == D_RESUME)         cmd = C_RESUME;
        end
        S_U1: if (at_second && wdata == D_UNLOCK2) step_n = S_U2;
        S_U2: begin
          if (at_first && wdata == D_SETUP)      step_n = S_E1;
          else if (at_first && wdata == D_PROG)  step_n = S_PGM;
          else if (at_first && wdata == D_IDENT) cmd = C_AUTOSEL;
        end
        S_E1: if (at_first && wdata == D_UNLOCK1)  step_n = S_E2;
        S_E2: if (at_second && wdata == D_UNLOCK2) step_n = S_E3;
        S_E3: begin
          if (at_first && wdata == D_CHIP) cmd = C_CHIP;
          else if (wdata == D_SECT)        cmd = C_SECT;
        end
        S_PGM: cmd = C_PROG;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) step <= S_IDLE;
    else        step <= step_n;
endmodule

// File: rtl/fc_halt_timer.sv
module fc_halt_timer #(
  parameter int SUSP_LAT = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(SUSP_LAT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(SUSP_LAT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
endmodule

// File: rtl/fc_read_mux.sv
module fc_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int          SECT_W = 4,
  parameter logic [7:0]  MFR_ID = 8'h3E,
  parameter logic [7:0]  DEV_ID = 8'h7A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  mode_e             st,
  input  logic              nest,
  input  logic [SECT_W-1:0] sect,
  input  logic [1:0]        id_sel,
  input  logic [SECT_W-1:0] psect,
  input  logic [SECT_W-1:0] esect,
  input  logic              pd7,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rdata
);
  logic q6, q2, q7, blocked, stat_sel, erase_live;
  logic [7:0] id_byte;

  assign erase_live = (st == M_ERASE) || (st == M_EHALT) || (st == M_ESUSP) ||
                      (nest && ((st == M_PROG) || (st == M_PHALT) || (st == M_PSUSP)));
  assign blocked = ((st == M_PSUSP) && ((sect == psect) || (nest && sect == esect))) ||
                   ((st == M_ESUSP) && (sect == esect));
  assign stat_sel = is_busy(st) || blocked;

  always_comb begin
    if ((st == M_PROG) || (st == M_PHALT))        q7 = ~pd7;
    else if ((st == M_ERASE) || (st == M_EHALT)) q7 = 1'b0;
    else                                         q7 = 1'b1;
    unique case (id_sel)
      2'b00:   id_byte = MFR_ID;
      2'b01:   id_byte = DEV_ID;
      default: id_byte = 8'h00;
    endcase
    if (st == M_AUTOSEL) rdata = id_byte;
    else if (stat_sel)   rdata = {q7, q6, 3'b000, q2, 2'b00};
    else                 rdata = arr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q6 <= 1'b0;
      q2 <= 1'b0;
    end else if (rd_en && stat_sel && st != M_AUTOSEL) begin
      if (is_busy(st)) q6 <= ~q6;
      if (erase_live)  q2 <= ~q2;
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         SECT_W   = 4,
  parameter int         SUSP_LAT = 600,
  parameter logic [7:0] MFR_ID   = 8'h3E,
  parameter logic [7:0] DEV_ID   = 8'h7A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              done,
  input  logic [7:0]        arr_data,
  output logic [2:0]        mode,
  output logic              ready,
  output logic [7:0]        rdata
);
  localparam int OFS_W = ADDR_W - SECT_W;

  mode_e st, st_n, ret_st, ret_n;
  cmd_e  cmd;
  logic  nest, nest_n, pd7, pd7_n, chip, chip_n, halt_done;
  logic [SECT_W-1:0] psect, psect_n, esect, esect_n, sect_in;

  assign sect_in = addr[ADDR_W-1 -: SECT_W];
  assign mode    = st;
  assign ready   = !is_busy(st);

  fc_seq_decoder #(.OFS_W(OFS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(is_busy(st)),
    .ofs(addr[OFS_W-1:0]), .wdata(wdata), .cmd(cmd)
  );

  fc_halt_timer #(.SUSP_LAT(SUSP_LAT)) u_halt (
    .clk(clk), .rst_n(rst_n), .run((st == M_PHALT) || (st == M_EHALT)),
    .expired(halt_done)
  );

  fc_read_mux #(.SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .st(st), .nest(nest),
    .sect(sect_in), .id_sel(addr[2:1]), .psect(psect), .esect(esect),
    .pd7(pd7), .arr_data(arr_data), .rdata(rdata)
  );

  always_comb begin
    st_n = st; ret_n = ret_st; nest_n = nest; pd7_n = pd7;
    chip_n = chip; psect_n = psect; esect_n = esect;
    unique case (st)
      M_READ: begin
        if (cmd == C_AUTOSEL) begin
          st_n = M_AUTOSEL; ret_n = M_READ;
        end else if (cmd == C_PROG) begin
          st_n = M_PROG; psect_n = sect_in; pd7_n = wdata[7];
        end else if (cmd == C_CHIP) begin
          st_n = M_ERASE; chip_n = 1'b1; esect_n = '0;
        end else if (cmd == C_SECT) begin
          st_n = M_ERASE; chip_n = 1'b0; esect_n = sect_in;
        end
      end
      M_AUTOSEL: if (cmd == C_EXIT) st_n = ret_st;
      M_PROG: begin
        if (done) begin
          st_n = nest ? M_ESUSP : M_READ; nest_n = 1'b0;
        end else if (cmd == C_SUSP) st_n = M_PHALT;
      end
      M_PHALT: if (halt_done) st_n = M_PSUSP;
      M_PSUSP: begin
        if (cmd == C_RESUME) st_n = M_PROG;
        else if (cmd == C_AUTOSEL) begin
          st_n = M_AUTOSEL; ret_n = M_PSUSP;
        end
      end
      M_ERASE: begin
        if (done) begin
          st_n = M_READ; esect_n = '0; chip_n = 1'b0;
        end else if (cmd == C_SUSP && !chip) st_n = M_EHALT;
      end
      M_EHALT: if (halt_done) st_n = M_ESUSP;
      M_ESUSP: begin
        if (cmd == C_RESUME) st_n = M_ERASE;
        else if (cmd == C_AUTOSEL) begin
          st_n = M_AUTOSEL; ret_n = M_ESUSP;
        end else if (cmd == C_PROG) begin
          st_n = M_PROG; nest_n = 1'b1; psect_n = sect_in; pd7_n = wdata[7];
        end
      end
      default: st_n = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= M_READ; ret_st <= M_READ; nest <= 1'b0; pd7 <= 1'b0;
      chip <= 1'b0; psect <= '0; esect <= '0;
    end else begin
      st <= st_n; ret_st <= ret_n; nest <= nest_n; pd7 <= pd7_n;
      chip <= chip_n; psect <= psect_n; esect <= esect_n;
    end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk
  import flash_cmd_pkg::*;
#(
  parameter int         SUSP_LAT = 600,
  parameter logic [7:0] MFR_ID   = 8'h3E
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] id_sel,
  input logic [7:0] wdata,
  input logic       done,
  input logic [2:0] mode,
  input logic       ready,
  input logic [7:0] rdata
);
  logic [31:0] hcnt;
  logic        halting;

  assign halting = (mode == M_PHALT) || (mode == M_EHALT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hcnt <= '0;
    else if (halting) hcnt <= hcnt + 1'b1;
    else              hcnt <= '0;

  a_r9_halt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    halting |-> (hcnt < SUSP_LAT));

  a_r9_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && wr_en && wdata == 8'hB0 && !done) |=> (mode == M_PHALT));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG || mode == M_ERASE || halting) |-> !ready);

  a_r7_erase_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && done) |=> (mode == M_READ));

  a_r6_prog_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && done) |=> (mode == M_READ || mode == M_ESUSP));

  a_r4_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == M_AUTOSEL && id_sel == 2'b00) |-> (rdata == MFR_ID));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.SUSP_LAT(SUSP_LAT), .MFR_ID(MFR_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .id_sel(addr[2:1]),
  .wdata(wdata), .done(done), .mode(mode), .ready(ready), .rdata(rdata)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  import flash_cmd_pkg::*;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DN = 2'd2, OP_ID = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a;
    logic [7:0]  d;
    logic [2:0]  m;
    logic        rdy;
    logic [7:0]  r;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 58;
  // Tags: R1 reset/array, R3 unlock, R4 ID codes, R5 exit return, R6 program,
  // R7 erase, R8 mismatch, R9 halt window, R10 resume, R11 nesting, R12 status
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 16'h0003, 8'h00, M_READ,    1'b1, 8'h13, 4'd1},
    '{OP_WR, 16'h0555, 8'hAA, M_READ,    1'b1, 8'h00, 4'd3},
    '{OP_WR, 16'h02AA, 8'h55, M_READ,    1'b1, 8'h00, 4'd3},
    '{OP_WR, 16'h0555, 8'h90, M_AUTOSEL, 1'b1, 8'h00, 4'd3},
    '{OP_RD, 16'h0000, 8'h00, M_AUTOSEL, 1'b1, 8'h3E, 4'd4},
    '{OP_RD, 16'h0002, 8'h00, M_AUTOSEL, 1'b1, 8'h7A, 4'd4},
    '{OP_RD, 16'h0004, 8'h00, M_AUTOSEL, 1'b1, 8'h00, 4'd4},
    '{OP_RD, 16'h0000, 8'h00, M_AUTOSEL, 1'b1, 8'h3E, 4'd4},
    '{OP_WR, 16'h0000, 8'hF0, M_READ,    1'b1, 8'h00, 4'd5},
    '{OP_RD, 16'h0005, 8'h00, M_READ,    1'b1, 8'h15, 4'd1},
    '{OP_WR, 16'h0555, 8'hAA, M_READ,    1'b1, 8'h00, 4'd6},
    '{OP_WR, 16'h02AA, 8'h55, M_READ,    1'b1, 8'h00, 4'd6},
    '{OP_WR, 16'h0555, 8'hA0, M_READ,    1'b1, 8'h00, 4'd6},
    '{OP_WR, 16'h1004, 8'h4C, M_PROG,    1'b0, 8'h00, 4'd6},
    '{OP_RD, 16'h1004, 8'h00, M_PROG,    1'b0, 8'h80, 4'd12},
    '{OP_RD, 16'h1004, 8'h00, M_PROG,    1'b0, 8'hC0, 4'd12},
    '{OP_DN, 16'h0000, 8'h00, M_READ,    1'b1, 8'h00, 4'd6},
    '{OP_RD, 16'h1004, 8'h00, M_READ,    1'b1, 8'h14, 4'd6},
    '{OP_WR, 16'h0555, 8'hAA, M_READ,    1'b1, 8'h00, 4'd8},
    '{OP_WR, 16'h02AA, 8'h77, M_READ,    1'b1, 8'h00, 4'd8},
    '{OP_WR, 16'h0555, 8'h90, M_READ,    1'b1, 8'h00, 4'd8},
    '{OP_WR, 16'h0555, 8'hAA, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_WR, 16'h02AA, 8'h55, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_WR, 16'h0555, 8'h80, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_WR, 16'h0555, 8'hAA, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_WR, 16'h02AA, 8'h55, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_WR, 16'h2000, 8'h30, M_ERASE,   1'b0, 8'h00, 4'd7},
    '{OP_RD, 16'h2000, 8'h00, M_ERASE,   1'b0, 8'h00, 4'd12},
    '{OP_RD, 16'h3000, 8'h00, M_ERASE,   1'b0, 8'h44, 4'd12},
    '{OP_WR, 16'h0000, 8'hB0, M_EHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_EHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_EHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_ESUSP,   1'b1, 8'h00, 4'd9},
    '{OP_RD, 16'h2000, 8'h00, M_ESUSP,   1'b1, 8'h80, 4'd11},
    '{OP_RD, 16'h5003, 8'h00, M_ESUSP,   1'b1, 8'h13, 4'd11},
    '{OP_WR, 16'h0555, 8'hAA, M_ESUSP,   1'b1, 8'h00, 4'd11},
    '{OP_WR, 16'h02AA, 8'h55, M_ESUSP,   1'b1, 8'h00, 4'd11},
    '{OP_WR, 16'h0555, 8'hA0, M_ESUSP,   1'b1, 8'h00, 4'd11},
    '{OP_WR, 16'h5001, 8'hC8, M_PROG,    1'b0, 8'h00, 4'd11},
    '{OP_RD, 16'h5001, 8'h00, M_PROG,    1'b0, 8'h04, 4'd12},
    '{OP_WR, 16'h0000, 8'hB0, M_PHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_PHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_PHALT,   1'b0, 8'h00, 4'd9},
    '{OP_ID, 16'h0000, 8'h00, M_PSUSP,   1'b1, 8'h00, 4'd9},
    '{OP_RD, 16'h5001, 8'h00, M_PSUSP,   1'b1, 8'hC0, 4'd11},
    '{OP_RD, 16'h2002, 8'h00, M_PSUSP,   1'b1, 8'hC4, 4'd11},
    '{OP_RD, 16'h7002, 8'h00, M_PSUSP,   1'b1, 8'h12, 4'd11},
    '{OP_WR, 16'h0555, 8'hAA, M_PSUSP,   1'b1, 8'h00, 4'd5},
    '{OP_WR, 16'h02AA, 8'h55, M_PSUSP,   1'b1, 8'h00, 4'd5},
    '{OP_WR, 16'h0555, 8'h90, M_AUTOSEL, 1'b1, 8'h00, 4'd5},
    '{OP_RD, 16'h0002, 8'h00, M_AUTOSEL, 1'b1, 8'h7A, 4'd4},
    '{OP_RD, 16'h0000, 8'h00, M_AUTOSEL, 1'b1, 8'h3E, 4'd4},
    '{OP_WR, 16'h0000, 8'hF0, M_PSUSP,   1'b1, 8'h00, 4'd5},
    '{OP_WR, 16'h0000, 8'h30, M_PROG,    1'b0, 8'h00, 4'd10},
    '{OP_DN, 16'h0000, 8'h00, M_ESUSP,   1'b1, 8'h00, 4'd6},
    '{OP_WR, 16'h0000, 8'h30, M_ERASE,   1'b0, 8'h00, 4'd10},
    '{OP_DN, 16'h0000, 8'h00, M_READ,    1'b1, 8'h00, 4'd7},
    '{OP_RD, 16'h2000, 8'h00, M_READ,    1'b1, 8'h10, 4'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, done = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, arr_data, rdata;
  logic [2:0]  mode;
  logic        ready;
  logic [7:0]  mem [16];
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  initial for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
  assign arr_data = mem[addr[3:0]];

  flash_cmd_fsm #(.ADDR_W(16), .SECT_W(4), .SUSP_LAT(3), .MFR_ID(8'h3E), .DEV_ID(8'h7A))
  u_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .done(done), .arr_data(arr_data), .mode(mode),
    .ready(ready), .rdata(rdata)
  );

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    @(negedge clk);
    addr = a; wdata = d;
    wr_en = (op == OP_WR); rd_en = (op == OP_RD); done = (op == OP_DN);
    #1 rd = rdata;
    @(posedge clk);
    #1 wr_en = 1'b0; rd_en = 1'b0; done = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    do_op(OP_WR, a, d, dummy);
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    check(1, 16'({mode, ready}), 16'({M_READ, 1'b1}));        // R1 reset state
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[i]) begin
      do_op(VEC[i].op, VEC[i].a, VEC[i].d, rv);
      if (VEC[i].op == OP_RD) check(int'(VEC[i].req), 16'(rv), 16'(VEC[i].r));
      check(int'(VEC[i].req), 16'({mode, ready}), 16'({VEC[i].m, VEC[i].rdy}));
    end

    // R13: chip erase ignores suspend and sequences
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h10);
    check(7, 16'({mode, ready}), 16'({M_ERASE, 1'b0}));
    wr(16'h0000, 8'hB0);
    repeat (4) @(negedge clk);
    check(13, 16'(mode), 16'(M_ERASE));
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h90);
    check(13, 16'(mode), 16'(M_ERASE));
    do_op(OP_DN, 16'h0, 8'h0, rv);
    check(7, 16'({mode, ready}), 16'({M_READ, 1'b1}));
    do_op(OP_RD, 16'h0001, 8'h0, rv);
    check(13, 16'(rv), 16'h0011);

    // R13: sector erase ignores an identification sequence; R1: reset aborts
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h4000, 8'h30);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h90);
    check(13, 16'(mode), 16'(M_ERASE));
    @(negedge clk) rst_n = 1'b0;
    #1 check(1, 16'({mode, ready}), 16'({M_READ, 1'b1}));
    @(negedge clk) rst_n = 1'b1;
    do_op(OP_RD, 16'h4006, 8'h0, rv);
    check(1, 16'(rv), 16'h0016);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule